// File: doc/BRIEF.md
# System Clock Division Controller

This block sets the operating rate of a chip from a single byte-wide control register and a free-running 5-bit prescaler. It drives two clock-enable strobes. `bus_en_o` paces the bus master. `chip_en_o` paces every other consumer: the peripherals and the clock-output pin. No clock is gated. Each consumer advances only on base-clock cycles where its strobe is high.

A mode bit decides what the 3-bit select field means. When the mode bit is clear, the select field slows only the bus master, down to one cycle in 32, while the rest of the chip stays at full rate. When the mode bit is set, the select field slows the whole chip, down to one cycle in 8.

A new ratio is applied only when the prescaler wraps, so no strobe period is ever cut short at a switch. A write that changes the mode bit and the select field together is applied in two stages. Any setting without a defined meaning runs at full rate and raises a sticky error flag.

Top module: `sysclk_div_ctrl`

## Requirements
- R1: A write stores the mode bit from data bit 5 and the select field from data bits 2..0. `rd_data_o` returns them in the same positions from the cycle after the write.
- R2: Data bits 7, 6, 4 and 3 cannot be stored and always read back as 0, whatever is written to them.
- R3: While reset is asserted and after it is released, the register reads 0x00, both strobes are high on every cycle and `cfg_err_o` is 0. The prescaler count is 0 in the first cycle after reset release and rises by 1 each cycle.
- R4: With select code 000 both strobes are high on every cycle, for either value of the mode bit.
- R5: With the mode bit at 0 and a select code s from 1 to 5, `bus_en_o` is high only in cycles where the prescaler count modulo 2^s equals 2^s-1, and `chip_en_o` is high on every cycle.
- R6: With the mode bit at 1 and a select code s from 1 to 3, `bus_en_o` and `chip_en_o` are both high only in cycles where the count modulo 2^s equals 2^s-1.
- R7: An undefined setting (mode 1 with code 100..111, or mode 0 with code 110 or 111) once applied runs both strobes at full rate. One cycle later `cfg_err_o` rises and stays high until reset.
- R8: A written setting takes effect in the first cycle whose count is 0 after the write. A write captured at the edge that ends count 31 waits for the following wrap.
- R9: When the applied mode bit differs from the stored one, a wrap applies only the mode bit. The select field is applied at the next wrap, 32 cycles later.
- R10: In every cycle with count 31 both strobes are high, so each strobe period ends completely before a ratio change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read-back value |
| bus_en_o | output | 1 | Clock-enable strobe for the bus master |
| chip_en_o | output | 1 | Clock-enable strobe for peripherals and the clock-output pin |
| cfg_err_o | output | 1 | Sticky flag for an applied undefined setting |

## Verification
The results are due at different times after a stimulus:
- Read-back appears one cycle after a write.
- A new setting reaches the strobes in the cycle where the count returns to 0. The strobes follow the count in the same cycle, with no register in between.
- The error flag trails the applied setting by one cycle.

The bench keeps its own count of cycles since reset and steps a cycle model once per cycle. It samples on the falling edge, before it drives the next inputs, so each comparison falls in exactly the cycle in which the result is due. Directed writes placed at counts 30 and 31 exercise the wrap boundary. Constrained-random writes with random gaps cover the remaining mode and code changes.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int CNT_W    = 5;
  localparam int SEL_W    = 3;
  localparam int DATA_W   = 8;
  localparam int MODE_POS = 5;
  localparam int K_W      = $clog2(CNT_W + 1);

  typedef struct packed {
    logic             mode;
    logic [SEL_W-1:0] sel;
  } cfg_t;
endpackage

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + 1'b1;
  end

  assign wrap_o = &cnt_o;
endmodule

// File: rtl/sysclk_cfg_reg.sv
module sysclk_cfg_reg
  import sysclk_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int MPOS = MODE_POS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wrap_i,
  output cfg_t          prog_o,
  output cfg_t          eff_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_o <= '0;
      eff_o  <= '0;
    end else begin
      if (wr_en_i) begin
        prog_o.mode <= wr_data_i[MPOS];
        prog_o.sel  <= wr_data_i[SEL_W-1:0];
      end
      // staged apply: mode first, select at a later wrap
      if (wrap_i) begin
        if (eff_o.mode != prog_o.mode) eff_o.mode <= prog_o.mode;
        else                           eff_o.sel  <= prog_o.sel;
      end
    end
  end
endmodule

// File: rtl/sysclk_ratio_decode.sv
module sysclk_ratio_decode
  import sysclk_pkg::*;
#(
  parameter int MED_MAX_K  = 5,
  parameter int FULL_MAX_K = 3
) (
  input  cfg_t           eff_i,
  output logic [K_W-1:0] bus_k_o,
  output logic [K_W-1:0] chip_k_o,
  output logic           undef_o
);
  localparam logic [SEL_W-1:0] MED_LIM  = SEL_W'(MED_MAX_K);
  localparam logic [SEL_W-1:0] FULL_LIM = SEL_W'(FULL_MAX_K);

  always_comb begin
    bus_k_o  = '0;
    chip_k_o = '0;
    undef_o  = 1'b0;
    if (eff_i.sel != '0) begin
      if (!eff_i.mode) begin
        if (eff_i.sel <= MED_LIM) bus_k_o = K_W'(eff_i.sel);
        else                      undef_o = 1'b1;
      end else begin
        if (eff_i.sel <= FULL_LIM) begin
          bus_k_o  = K_W'(eff_i.sel);
          chip_k_o = K_W'(eff_i.sel);
        end else begin
          undef_o = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sysclk_strobe_gen.sv
module sysclk_strobe_gen #(
  parameter int CNT_W = 5,
  parameter int N_OUT = 2,
  parameter int K_W   = 3
) (
  input  logic [CNT_W-1:0]          cnt_i,
  input  logic [N_OUT-1:0][K_W-1:0] k_i,
  output logic [N_OUT-1:0]          en_o
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_strb
    logic [CNT_W-1:0] mask;
    assign mask    = ~({CNT_W{1'b1}} << k_i[g]);
    assign en_o[g] = (cnt_i & mask) == mask;
  end
endmodule

// File: rtl/sysclk_div_ctrl.sv
module sysclk_div_ctrl
  import sysclk_pkg::*;
#(
  parameter int PCNT_W     = CNT_W,
  parameter int DW         = DATA_W,
  parameter int MPOS       = MODE_POS,
  parameter int MED_MAX_K  = 5,
  parameter int FULL_MAX_K = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          bus_en_o,
  output logic          chip_en_o,
  output logic          cfg_err_o
);
  localparam int N_OUT = 2;

  logic [PCNT_W-1:0]         pre_cnt;
  logic                      pre_wrap;
  cfg_t                      prog_cfg, eff_cfg;
  logic [K_W-1:0]            bus_k, chip_k;
  logic                      undef;
  logic [N_OUT-1:0][K_W-1:0] k_vec;
  logic [N_OUT-1:0]          en_vec;
  logic                      err_q;

  sysclk_prescaler #(.CNT_W(PCNT_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (pre_cnt),
    .wrap_o(pre_wrap)
  );

  sysclk_cfg_reg #(.DW(DW), .MPOS(MPOS)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .wrap_i   (pre_wrap),
    .prog_o   (prog_cfg),
    .eff_o    (eff_cfg)
  );

  sysclk_ratio_decode #(.MED_MAX_K(MED_MAX_K), .FULL_MAX_K(FULL_MAX_K)) u_dec (
    .eff_i   (eff_cfg),
    .bus_k_o (bus_k),
    .chip_k_o(chip_k),
    .undef_o (undef)
  );

  assign k_vec = {chip_k, bus_k};

  sysclk_strobe_gen #(.CNT_W(PCNT_W), .N_OUT(N_OUT), .K_W(K_W)) u_strb (
    .cnt_i(pre_cnt),
    .k_i  (k_vec),
    .en_o (en_vec)
  );

  assign bus_en_o  = en_vec[0];
  assign chip_en_o = en_vec[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (undef) err_q <= 1'b1;
  end
  assign cfg_err_o = err_q;

  always_comb begin
    rd_data_o                = '0;
    rd_data_o[MPOS]          = prog_cfg.mode;
    rd_data_o[SEL_W-1:0]     = prog_cfg.sel;
  end
endmodule

// File: rtl/sysclk_div_ctrl_chk.sv
module sysclk_div_ctrl_chk #(
  parameter int PCNT_W = 5,
  parameter int DW     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DW-1:0]     wr_data_i,
  input logic [DW-1:0]     rd_data_o,
  input logic              bus_en_o,
  input logic              chip_en_o,
  input logic              cfg_err_o,
  input logic [PCNT_W-1:0] cnt_i,
  input logic              eff_mode_i,
  input logic [2:0]        eff_sel_i
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7:6] == 2'b00 && rd_data_o[4:3] == 2'b00);  // R2

  AST_RD_FOLLOWS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[5] == $past(wr_data_i[5]) && rd_data_o[2:0] == $past(wr_data_i[2:0]));  // R1

  AST_BUS_IMPLIES_CHIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o |-> chip_en_o);  // R6

  AST_WRAP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_i) |-> (bus_en_o && chip_en_o));  // R10

  AST_APPLY_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != '0) |-> ($stable(eff_mode_i) && $stable(eff_sel_i)));  // R8

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);  // R7
endmodule

bind sysclk_div_ctrl sysclk_div_ctrl_chk #(.PCNT_W(PCNT_W), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .bus_en_o  (bus_en_o),
  .chip_en_o (chip_en_o),
  .cfg_err_o (cfg_err_o),
  .cnt_i     (pre_cnt),
  .eff_mode_i(eff_cfg.mode),
  .eff_sel_i (eff_cfg.sel)
);

// File: tb/sysclk_div_ctrl_tb_top.sv
`timescale 1ns/1ps
module sysclk_div_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       bus_en, chip_en, cfg_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  string cur_req = "R3";

  // bench cycle model
  logic [4:0] cnt_m;
  logic       mode_m, eff_mode_m, err_m;
  logic [2:0] sel_m, eff_sel_m;

  always #2.5 clk = ~clk;

  sysclk_div_ctrl dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en),
    .wr_data_i(wr_data),
    .rd_data_o(rd_data),
    .bus_en_o (bus_en),
    .chip_en_o(chip_en),
    .cfg_err_o(cfg_err)
  );

  function automatic bit undef_f(input logic m, input logic [2:0] s);
    if (s == 3'd0) return 1'b0;
    if (!m) return s > 3'd5;
    return s > 3'd3;
  endfunction

  function automatic int bus_k_f(input logic m, input logic [2:0] s);
    if (undef_f(m, s)) return 0;
    return int'(s);
  endfunction

  function automatic int chip_k_f(input logic m, input logic [2:0] s);
    if (undef_f(m, s) || !m) return 0;
    return int'(s);
  endfunction

  function automatic bit strobe_f(input int k, input logic [4:0] c);
    int p;
    p = 1 << k;
    return (int'(c) % p) == p - 1;
  endfunction

  task automatic cmp(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (cnt %0d)", req, what, act, exp, cnt_m);
    end
  endtask

  task automatic check_now();
    cmp("R1 R2", "rd_data", rd_data, {2'b00, mode_m, 2'b00, sel_m});
    cmp(cur_req, "bus_en", {7'd0, bus_en}, {7'd0, strobe_f(bus_k_f(eff_mode_m, eff_sel_m), cnt_m)});
    cmp(cur_req, "chip_en", {7'd0, chip_en}, {7'd0, strobe_f(chip_k_f(eff_mode_m, eff_sel_m), cnt_m)});
    cmp("R7", "cfg_err", {7'd0, cfg_err}, {7'd0, err_m});
    if (cnt_m == 5'd31) begin
      cmp("R10", "bus_en at count 31", {7'd0, bus_en}, 8'd1);
      cmp("R10", "chip_en at count 31", {7'd0, chip_en}, 8'd1);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] d);
    check_now();
    wr_en   = we;
    wr_data = d;
    if (undef_f(eff_mode_m, eff_sel_m)) err_m = 1'b1;
    if (cnt_m == 5'd31) begin
      if (eff_mode_m != mode_m) eff_mode_m = mode_m;
      else                      eff_sel_m  = sel_m;
    end
    if (we) begin
      mode_m = d[5];
      sel_m  = d[2:0];
    end
    cnt_m = cnt_m + 5'd1;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00);
  endtask

  task automatic wr(input logic [7:0] d);
    step(1'b1, d);
  endtask

  task automatic wait_cnt(input logic [4:0] c);
    while (cnt_m != c) step(1'b0, 8'h00);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    cnt_m = '0; mode_m = 1'b0; sel_m = '0;
    eff_mode_m = 1'b0; eff_sel_m = '0; err_m = 1'b0;
    repeat (2) @(negedge clk);
    begin
      string keep;
      keep = cur_req;
      cur_req = "R3";
      check_now();  // R3 during reset
      cur_req = keep;
    end
    rst_n = 1'b1;
  endtask

  initial begin
    #(500_000ns);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    cur_req = "R3";
    run(40);

    cur_req = "R5";  // reserved bits also written here (R2)
    for (int s = 1; s <= 5; s++) begin
      wr(8'hD8 | 8'(s));
      run(100);
    end

    cur_req = "R4";
    wr(8'h00); run(70);
    wr(8'h20); run(70);

    cur_req = "R6";
    for (int s = 1; s <= 3; s++) begin
      wr(8'h20 | 8'(s));
      run(100);
    end

    cur_req = "R9";  // mode 1 sel 3 -> mode 0 sel 2 in one write
    wr(8'h02);
    run(100);

    cur_req = "R8";
    wait_cnt(5'd30); wr(8'h04); run(40);
    wait_cnt(5'd31); wr(8'h01); run(80);

    cur_req = "R7";
    do_reset(); wr(8'h24); run(80);
    do_reset(); wr(8'h07); run(80);
    do_reset(); wr(8'h20); run(40); wr(8'h25); run(80);

    cur_req = "R8";
    do_reset();
    for (int i = 0; i < 40; i++) begin
      wr(8'($urandom));
      run(int'($urandom % 40));
    end
    run(70);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule